// File: doc/BRIEF.md
# Resonant Sustain Gate Sequencer

This block produces the gate enables for the sustain stage of a capacitive display panel. The stage returns the panel charge through a resonant inductor path. Each sustain pulse on a side moves through four switch phases: a resonant rise, a clamp to the sustain rail, a resonant fall and a clamp to ground. While one side pulses, the opposite side is held on its ground clamp. The pulses alternate, Y side first and then X side, for a programmed number of pairs. Both path switches stay enabled for the whole burst.

Between any two phases on the pulsing side, the sequencer inserts a dead interval with all four of that side's switches off, so no two rail switches ever overlap. The phase lengths, the dead interval and the pair count are captured when the burst starts. The durations are given in clock cycles; at a 200 MHz clock, a 300–400 ns resonant edge is 60–80 cycles. When the burst ends, a done flag goes high, and the block rests with both sides on ground and the path switches off.

Top module: `sustain_seq`

## Requirements
- R1: After reset and whenever idle, `y_gnd` and `x_gnd` are 1. All other gate enables, both path enables and `busy` are 0. After reset, `done` is 0.
- R2: A `start` sampled high while idle with `pair_count` nonzero sets `busy` from the next cycle. A pulse on the active side runs its phases in the fixed order rise, hold, fall, ground.
- R3: Each phase lasts exactly its programmed number of cycles (`rise_len`, `hold_len`, `fall_len`, `gnd_len`). A programmed value of 0 lasts one cycle.
- R4: Before each of the four phases, including the first rise of a pulse, the active side spends `dead_len` cycles (0 counts as 1) with its four enables all 0.
- R5: During a pulse on one side, the other side shows only its ground enable.
- R6: Pulses alternate Y then X, and one burst holds exactly `pair_count` Y/X pairs.
- R7: `path_main_en` and `path_scan_en` are 1 in exactly the cycles in which `busy` is 1.
- R8: In the cycle after the last X ground phase ends, `busy` falls and `done` becomes 1. `done` holds until the next accepted start clears it.
- R9: While `busy`, `start` is ignored, and changes to `pair_count` or to any duration input do not change the running burst.
- R10: A `start` with `pair_count` equal to 0 is ignored: the outputs, including `done`, stay as they were.
- R11: On each side, at most one of the rise, hold, fall and ground enables is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request, sampled while idle |
| pair_count | input | CNT_W | Number of Y/X pulse pairs |
| rise_len | input | DUR_W | Resonant rise phase length, cycles |
| hold_len | input | DUR_W | Sustain clamp phase length, cycles |
| fall_len | input | DUR_W | Resonant fall phase length, cycles |
| gnd_len | input | DUR_W | Ground clamp phase length, cycles |
| dead_len | input | DUR_W | Dead interval before each phase, cycles |
| y_rise | output | 1 | Y resonant rise switch enable |
| y_hold | output | 1 | Y sustain clamp switch enable |
| y_fall | output | 1 | Y resonant fall switch enable |
| y_gnd | output | 1 | Y ground clamp switch enable |
| x_rise | output | 1 | X resonant rise switch enable |
| x_hold | output | 1 | X sustain clamp switch enable |
| x_fall | output | 1 | X resonant fall switch enable |
| x_gnd | output | 1 | X ground clamp switch enable |
| path_main_en | output | 1 | Main path switch enable |
| path_scan_en | output | 1 | Scan-side path switch enable |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst completed |

## Verification
The assertions assume only that reset is applied at the start. They place no constraint on `start` or on the duration inputs. The switch-exclusion and dead-interval properties must hold for any input pattern, including requests made mid-burst and zero-length settings. The stimulus uses this freedom on purpose. It sweeps every combination of phase lengths 1 and 2, dead lengths 1 and 2, and pair counts 1 and 2. It also issues a start request during a burst, rewrites the duration inputs right after each start, and programs zero values. Every cycle of each burst is compared with a trace that the bench computes from the latched settings.

// File: rtl/sus_pkg.sv
package sus_pkg;

    typedef enum logic [2:0] {
        PH_DEAD = 3'd0,
        PH_RISE = 3'd1,
        PH_HOLD = 3'd2,
        PH_FALL = 3'd3,
        PH_GND  = 3'd4
    } phase_e;

    typedef struct packed {
        logic rise;
        logic hold;
        logic fall;
        logic gnd;
    } gate_s;

    localparam int NSIDES = 2;

    function automatic phase_e following(input phase_e p);
        case (p)
            PH_RISE: return PH_HOLD;
            PH_HOLD: return PH_FALL;
            PH_FALL: return PH_GND;
            default: return PH_RISE;
        endcase
    endfunction

endpackage

// File: rtl/sus_phase_timer.sv
module sus_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sus_gate_decode.sv
module sus_gate_decode
    import sus_pkg::*;
(
    input  logic   busy,
    input  logic   active,
    input  phase_e phase,
    output gate_s  gates
);
    always_comb begin
        gates = '{rise: 1'b0, hold: 1'b0, fall: 1'b0, gnd: 1'b0};
        if (!busy || !active) begin
            gates.gnd = 1'b1;
        end else begin
            case (phase)
                PH_RISE: gates.rise = 1'b1;
                PH_HOLD: gates.hold = 1'b1;
                PH_FALL: gates.fall = 1'b1;
                PH_GND:  gates.gnd  = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sustain_seq.sv
module sustain_seq
    import sus_pkg::*;
#(
    parameter int DUR_W = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pair_count,
    input  logic [DUR_W-1:0] rise_len,
    input  logic [DUR_W-1:0] hold_len,
    input  logic [DUR_W-1:0] fall_len,
    input  logic [DUR_W-1:0] gnd_len,
    input  logic [DUR_W-1:0] dead_len,
    output logic             y_rise,
    output logic             y_hold,
    output logic             y_fall,
    output logic             y_gnd,
    output logic             x_rise,
    output logic             x_hold,
    output logic             x_fall,
    output logic             x_gnd,
    output logic             path_main_en,
    output logic             path_scan_en,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE_PAIR = CNT_W'(1);

    // Reload value for a segment: length minus one, zero treated as one
    function automatic logic [DUR_W-1:0] reload(input logic [DUR_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    logic             side_x, side_x_n;
    logic             busy_n, done_n;
    phase_e           phase, phase_n, upcoming, upcoming_n;
    logic [CNT_W-1:0] pairs_left, pairs_n;
    logic [DUR_W-1:0] rise_m1, hold_m1, fall_m1, gnd_m1, dead_m1;
    logic             accept, expired, ld;
    logic [DUR_W-1:0] ld_val;
    gate_s            gates [NSIDES];

    assign accept = !busy && start && (pair_count != '0);

    sus_phase_timer #(.W(DUR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    always_comb begin
        side_x_n   = side_x;
        busy_n     = busy;
        done_n     = done;
        phase_n    = phase;
        upcoming_n = upcoming;
        pairs_n    = pairs_left;
        ld         = 1'b0;
        ld_val     = dead_m1;
        if (accept) begin
            busy_n     = 1'b1;
            done_n     = 1'b0;
            side_x_n   = 1'b0;
            phase_n    = PH_DEAD;
            upcoming_n = PH_RISE;
            pairs_n    = pair_count;
            ld         = 1'b1;
            ld_val     = reload(dead_len);
        end else if (busy && expired) begin
            case (phase)
                PH_DEAD: begin
                    phase_n = upcoming;
                    ld      = 1'b1;
                    case (upcoming)
                        PH_RISE: ld_val = rise_m1;
                        PH_HOLD: ld_val = hold_m1;
                        PH_FALL: ld_val = fall_m1;
                        default: ld_val = gnd_m1;
                    endcase
                end
                PH_GND: begin
                    if (!side_x) begin
                        side_x_n   = 1'b1;
                        phase_n    = PH_DEAD;
                        upcoming_n = PH_RISE;
                        ld         = 1'b1;
                    end else if (pairs_left == ONE_PAIR) begin
                        busy_n = 1'b0;
                        done_n = 1'b1;
                    end else begin
                        pairs_n    = pairs_left - 1'b1;
                        side_x_n   = 1'b0;
                        phase_n    = PH_DEAD;
                        upcoming_n = PH_RISE;
                        ld         = 1'b1;
                    end
                end
                default: begin
                    phase_n    = PH_DEAD;
                    upcoming_n = following(phase);
                    ld         = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_x     <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            phase      <= PH_GND;
            upcoming   <= PH_RISE;
            pairs_left <= '0;
            rise_m1    <= '0;
            hold_m1    <= '0;
            fall_m1    <= '0;
            gnd_m1     <= '0;
            dead_m1    <= '0;
        end else begin
            side_x     <= side_x_n;
            busy       <= busy_n;
            done       <= done_n;
            phase      <= phase_n;
            upcoming   <= upcoming_n;
            pairs_left <= pairs_n;
            if (accept) begin
                rise_m1 <= reload(rise_len);
                hold_m1 <= reload(hold_len);
                fall_m1 <= reload(fall_len);
                gnd_m1  <= reload(gnd_len);
                dead_m1 <= reload(dead_len);
            end
        end
    end

    // Side 0 is Y, side 1 is X
    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        sus_gate_decode u_dec (
            .busy   (busy),
            .active (side_x == 1'(s)),
            .phase  (phase),
            .gates  (gates[s])
        );
    end

    assign {y_rise, y_hold, y_fall, y_gnd} = gates[0];
    assign {x_rise, x_hold, x_fall, x_gnd} = gates[1];
    assign path_main_en = busy;
    assign path_scan_en = busy;
endmodule

// File: rtl/sustain_seq_chk.sv
module sustain_seq_chk (
    input logic clk,
    input logic rst,
    input logic y_rise,
    input logic y_hold,
    input logic y_fall,
    input logic y_gnd,
    input logic x_rise,
    input logic x_hold,
    input logic x_fall,
    input logic x_gnd,
    input logic path_main_en,
    input logic path_scan_en,
    input logic busy,
    input logic done
);
    logic [3:0] yv, xv;
    assign yv = {y_rise, y_hold, y_fall, y_gnd};
    assign xv = {x_rise, x_hold, x_fall, x_gnd};

    a_r11_y_exclusive: assert property (@(posedge clk) disable iff (rst) $onehot0(yv));
    a_r11_x_exclusive: assert property (@(posedge clk) disable iff (rst) $onehot0(xv));

    a_r1_idle_grounded: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (y_gnd && x_gnd && !path_main_en && !path_scan_en));

    a_r5_x_passive: assert property (@(posedge clk) disable iff (rst)
        (y_rise || y_hold || y_fall) |-> (xv == 4'b0001));
    a_r5_y_passive: assert property (@(posedge clk) disable iff (rst)
        (x_rise || x_hold || x_fall) |-> (yv == 4'b0001));

    a_r4_y_dead_before_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(y_rise) |-> ($past(yv) == 4'b0000));
    a_r4_y_dead_before_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(y_hold) |-> ($past(yv) == 4'b0000));
    a_r4_x_dead_before_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(x_fall) |-> ($past(xv) == 4'b0000));

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r7_paths_follow_busy: assert property (@(posedge clk) disable iff (rst)
        (path_main_en == busy) && (path_scan_en == busy));
endmodule

bind sustain_seq sustain_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .y_rise       (y_rise),
    .y_hold       (y_hold),
    .y_fall       (y_fall),
    .y_gnd        (y_gnd),
    .x_rise       (x_rise),
    .x_hold       (x_hold),
    .x_fall       (x_fall),
    .x_gnd        (x_gnd),
    .path_main_en (path_main_en),
    .path_scan_en (path_scan_en),
    .busy         (busy),
    .done         (done)
);

// File: tb/sustain_seq_test.sv
module sustain_seq_test;
    localparam int DUR_W = 4;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] pair_count = '0;
    logic [DUR_W-1:0] rise_len = '0, hold_len = '0, fall_len = '0, gnd_len = '0, dead_len = '0;
    logic y_rise, y_hold, y_fall, y_gnd, x_rise, x_hold, x_fall, x_gnd;
    logic path_main_en, path_scan_en, busy, done;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sustain_seq #(.DUR_W(DUR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .start(start), .pair_count(pair_count),
        .rise_len(rise_len), .hold_len(hold_len), .fall_len(fall_len),
        .gnd_len(gnd_len), .dead_len(dead_len),
        .y_rise(y_rise), .y_hold(y_hold), .y_fall(y_fall), .y_gnd(y_gnd),
        .x_rise(x_rise), .x_hold(x_hold), .x_fall(x_fall), .x_gnd(x_gnd),
        .path_main_en(path_main_en), .path_scan_en(path_scan_en),
        .busy(busy), .done(done)
    );

    // {busy, done, path_main, path_scan, y rise/hold/fall/gnd, x rise/hold/fall/gnd}
    function automatic logic [11:0] observed();
        return {busy, done, path_main_en, path_scan_en,
                y_rise, y_hold, y_fall, y_gnd, x_rise, x_hold, x_fall, x_gnd};
    endfunction

    localparam logic [11:0] IDLE_DONE  = 12'b0100_0001_0001;
    localparam logic [11:0] IDLE_FRESH = 12'b0000_0001_0001;

    task automatic chk(input logic [11:0] exp, input string req);
        logic [11:0] got;
        got = observed();
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: outputs actual=%b expected=%b at t=%0t", req, got, exp, $time);
        end
    endtask

    // Expected vector for a cycle: seg 0 dead, 1 rise, 2 hold, 3 fall, 4 ground
    function automatic logic [11:0] busy_vec(input int side, input int seg);
        logic [3:0] act;
        case (seg)
            1: act = 4'b1000;
            2: act = 4'b0100;
            3: act = 4'b0010;
            4: act = 4'b0001;
            default: act = 4'b0000;
        endcase
        return (side == 0) ? {4'b1011, act, 4'b0001} : {4'b1011, 4'b0001, act};
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // One burst; settings are overwritten after start (R9); glitch>=0 injects a start mid-burst
    task automatic run_cfg(input int r, input int h, input int f, input int g,
                           input int d, input int pairs, input int glitch);
        int lens[5];
        int idx;
        lens[0] = eff(d); lens[1] = eff(r); lens[2] = eff(h);
        lens[3] = eff(f); lens[4] = eff(g);
        @(negedge clk);
        rise_len = DUR_W'(r); hold_len = DUR_W'(h); fall_len = DUR_W'(f);
        gnd_len = DUR_W'(g); dead_len = DUR_W'(d); pair_count = CNT_W'(pairs);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rise_len = 4'd7; hold_len = 4'd7; fall_len = 4'd7; gnd_len = 4'd7;
        dead_len = 4'd7; pair_count = 4'd9;
        idx = 0;
        for (int p = 0; p < pairs; p++) begin
            for (int side = 0; side < 2; side++) begin
                for (int ph = 1; ph <= 4; ph++) begin
                    for (int c = 0; c < lens[0]; c++) begin
                        chk(busy_vec(side, 0), "R4 R5 R7");
                        if (idx == glitch) start = 1'b1;
                        else start = 1'b0;
                        idx++;
                        @(negedge clk);
                    end
                    for (int c = 0; c < lens[ph]; c++) begin
                        chk(busy_vec(side, ph), "R2 R3 R5 R6 R9");
                        if (idx == glitch) start = 1'b1;
                        else start = 1'b0;
                        idx++;
                        @(negedge clk);
                    end
                end
            end
        end
        start = 1'b0;
        chk(IDLE_DONE, "R8");
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(IDLE_FRESH, "R1");

        // R10: zero pair count request right after reset
        start = 1'b1;
        pair_count = '0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(IDLE_FRESH, "R10");
            @(negedge clk);
        end

        // Sweep of phase, dead and pair settings (R2 R3 R4 R5 R6 R7 R8)
        for (int pr = 1; pr <= 2; pr++)
            for (int d = 1; d <= 2; d++)
                for (int r = 1; r <= 2; r++)
                    for (int h = 1; h <= 2; h++)
                        for (int f = 1; f <= 2; f++)
                            for (int g = 1; g <= 2; g++)
                                run_cfg(r, h, f, g, d, pr, -1);

        // R3 R4: zero-valued settings behave as one cycle
        run_cfg(0, 0, 0, 0, 0, 1, -1);
        run_cfg(3, 0, 2, 0, 0, 2, -1);

        // R9: start during a burst is ignored
        run_cfg(2, 3, 2, 1, 1, 2, 3);
        run_cfg(1, 1, 1, 1, 2, 1, 10);

        // R10: zero pair count while done is set leaves done intact
        @(negedge clk);
        start = 1'b1;
        pair_count = '0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(IDLE_DONE, "R10");
            @(negedge clk);
        end

        // R1: reset mid-burst returns to the idle state with done cleared
        pair_count = 4'd3; dead_len = 4'd2; rise_len = 4'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(IDLE_FRESH, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule